// File: doc/BRIEF.md
# Isolated Gate-Drive Pulse Encoder

This block turns a per-cycle switch on-time request into a pair of drive signals for a single isolation pulse transformer. The switching period comes from dividing the fast system clock, so all timing is a whole number of system-clock cycles. In encoded operation the two outputs form a complementary carrier. The positive half of the carrier starts with the switch on-time at the start of each period. The negative half starts at the maximum-duty point. The end of the on-time is marked by a short notch in which both outputs are low. Because the carrier stays close to a square wave, the same line pair can carry bias power as well as the gate timing.

A two-bit mode input picks encoded or plain output and a maximum duty of 50% or 75%. In plain operation the positive output carries an ordinary PWM pulse. The negative output carries a half-period clock that starts at the same edge as that pulse. The on-time request and the mode are captured once per period, at the period start. Requests at or past the maximum-duty point are clipped to that point.

Top module: `pte_encoder`

## Requirements
- R1: While rst_n is low, and from the second clock edge after enable is sampled low, both pt_p and pt_n are low.
- R2: In encoded mode (mode bit 1 = 0), for phase counts 0 up to the maximum-duty point minus one, pt_p is high and pt_n is low. For the remaining counts of the period, pt_p is low and pt_n is high. The notch of R3 is the only exception.
- R3: In encoded mode with a request below the maximum-duty point, both outputs are low for NOTCH_CYC counts, starting at the phase count equal to the request. NOTCH_CYC defaults to 8, which at 50 MHz is the count closest to 150 ns.
- R4: In encoded mode, a request of 0 places the notch at phase counts 0 to NOTCH_CYC-1, at the very start of the positive half.
- R5: In encoded mode, a notch that would run past the maximum-duty point is cut off there, and the negative half begins on schedule.
- R6: A request equal to or above the maximum-duty point is clipped to that point. In encoded mode no notch appears in that period. In plain mode the PWM output stays high up to the maximum-duty point.
- R7: In plain mode (mode bit 1 = 1), pt_p is high for phase counts below the clipped request. pt_n is high for phase counts below PERIOD/2.
- R8: Mode bit 0 selects the maximum-duty point: 0 gives PERIOD/2 and 1 gives 3*PERIOD/4.
- R9: The request and the mode are captured at the start of each period. A change made during a period takes effect in the next period. Phase count 0 appears on the outputs one clock after the capture edge; the first capture is the first edge at which enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the period counter when high |
| mode | input | 2 | Bit 1: plain output; bit 0: 75% maximum duty |
| on_time | input | REQ_W | Requested on-time in system-clock cycles |
| pt_p | output | 1 | Positive transformer drive |
| pt_n | output | 1 | Negative transformer drive |

## Verification
The bench compares every phase count of whole periods against a model of its own. It aims at the places where an encoder tends to slip. A zero request must put the notch at count 0; an off-by-one design would move it or drop it. A request just below the maximum-duty point must have its notch cut off at that point; a design that gets this wrong would swallow the start of the negative half. A request above the limit must give an unbroken positive half; a design that gets this wrong would leave a stray notch or stretch the pulse past the limit. The bench also changes the request and the mode in the middle of a period. A design that does not capture them once per period would bend the waveform of the current period.

// File: rtl/pte_pkg.sv
// Shared types for the pulse-transformer encoder.
package pte_pkg;

    // Output style and duty limit; bit 1 = plain, bit 0 = 75% limit.
    typedef enum logic [1:0] {
        MODE_ENC50   = 2'b00,
        MODE_ENC75   = 2'b01,
        MODE_PLAIN50 = 2'b10,
        MODE_PLAIN75 = 2'b11
    } drv_mode_e;

endpackage

// File: rtl/pte_phase_timer.sv
// Period divider: counts system clocks from 0 to PERIOD-1.
// At each period start it captures the on-time request and the mode.
// Assumes PERIOD >= 4. Holds at count 0 and stops while enable is low.
module pte_phase_timer
    import pte_pkg::*;
#(
    parameter int PERIOD = 100,
    parameter int PH_W   = 7,
    parameter int REQ_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [REQ_W-1:0] on_req,
    input  drv_mode_e        mode_req,
    output logic             run_q,
    output logic [PH_W-1:0]  ph_q,
    output logic [REQ_W-1:0] on_q,
    output drv_mode_e        mode_q
);

    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    // Advance the phase and capture the request at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            ph_q   <= '0;
            on_q   <= '0;
            mode_q <= MODE_ENC50;
        end else if (!enable) begin
            run_q <= 1'b0;
            ph_q  <= '0;
        end else if (!run_q || ph_q == LAST) begin
            run_q  <= 1'b1;
            ph_q   <= '0;
            on_q   <= on_req;
            mode_q <= mode_req;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

endmodule

// File: rtl/pte_shaper.sv
// Waveform shaper: from the phase, the captured request and the mode,
// forms either the notched complementary carrier or the plain PWM with
// its reference clock, and registers both drive outputs.
// Assumes NOTCH_CYC > 0 and a phase that stays below PERIOD.
module pte_shaper
    import pte_pkg::*;
#(
    parameter int PERIOD    = 100,
    parameter int PH_W      = 7,
    parameter int REQ_W     = 8,
    parameter int NOTCH_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PH_W-1:0]  ph,
    input  logic [REQ_W-1:0] on_lat,
    input  drv_mode_e        mode_lat,
    output logic             pt_p,
    output logic             pt_n,
    output logic             live_enc
);

    localparam int CW = PH_W + REQ_W + 1;
    localparam logic [CW-1:0] D50   = CW'(PERIOD / 2);
    localparam logic [CW-1:0] D75   = CW'((PERIOD * 3) / 4);
    localparam logic [CW-1:0] NW    = CW'(NOTCH_CYC);

    logic [CW-1:0] ph_w, on_w, dmax_w, nsum_w, nend_w, pw_end_w;
    logic          pos_half, clip, in_notch, pwm, ref_clk;
    logic          nxt_p, nxt_n;

    // Decode phase regions for the captured request.
    always_comb begin
        ph_w     = CW'(ph);
        on_w     = CW'(on_lat);
        dmax_w   = mode_lat[0] ? D75 : D50;
        nsum_w   = on_w + NW;
        nend_w   = (nsum_w > dmax_w) ? dmax_w : nsum_w;
        clip     = (on_w >= dmax_w);
        pw_end_w = clip ? dmax_w : on_w;
        pos_half = (ph_w < dmax_w);
        in_notch = !clip && (ph_w >= on_w) && (ph_w < nend_w);
        pwm      = (ph_w < pw_end_w);
        ref_clk  = (ph_w < D50);
    end

    // Select the output style from the captured mode.
    always_comb begin
        if (mode_lat[1]) begin
            nxt_p = pwm;
            nxt_n = ref_clk;
        end else begin
            nxt_p = pos_half && !in_notch;
            nxt_n = !pos_half;
        end
    end

    // Register the drive pair; both low while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pt_p     <= 1'b0;
            pt_n     <= 1'b0;
            live_enc <= 1'b0;
        end else begin
            pt_p     <= nxt_p;
            pt_n     <= nxt_n;
            live_enc <= !mode_lat[1];
        end
    end

endmodule

// File: rtl/pte_encoder.sv
// Top level of the pulse-transformer gate-drive encoder.
// Period length and notch width are set in system-clock cycles.
// The default notch is the count nearest NOTCH_NS at CLK_MHZ.
module pte_encoder
    import pte_pkg::*;
#(
    parameter int PERIOD   = 100,
    parameter int REQ_W    = 8,
    parameter int CLK_MHZ  = 50,
    parameter int NOTCH_NS = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic [REQ_W-1:0] on_time,
    output logic             pt_p,
    output logic             pt_n
);

    localparam int PH_W      = $clog2(PERIOD);
    localparam int NOTCH_RAW = (NOTCH_NS * CLK_MHZ + 500) / 1000;
    localparam int NOTCH_CYC = (NOTCH_RAW < 1) ? 1 : NOTCH_RAW;

    logic             run_q;
    logic [PH_W-1:0]  ph_q;
    logic [REQ_W-1:0] on_q;
    drv_mode_e        mode_q;
    logic             enc_live;

    pte_phase_timer #(
        .PERIOD (PERIOD),
        .PH_W   (PH_W),
        .REQ_W  (REQ_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .on_req   (on_time),
        .mode_req (drv_mode_e'(mode)),
        .run_q    (run_q),
        .ph_q     (ph_q),
        .on_q     (on_q),
        .mode_q   (mode_q)
    );

    pte_shaper #(
        .PERIOD    (PERIOD),
        .PH_W      (PH_W),
        .REQ_W     (REQ_W),
        .NOTCH_CYC (NOTCH_CYC)
    ) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .ph       (ph_q),
        .on_lat   (on_q),
        .mode_lat (mode_q),
        .pt_p     (pt_p),
        .pt_n     (pt_n),
        .live_enc (enc_live)
    );

endmodule

// File: rtl/pte_encoder_chk.sv
// Property checker for the pulse-transformer encoder, bound to the top.
// Run lengths are checked with counters, so no delay depends on a parameter.
module pte_encoder_chk #(
    parameter int NOTCH_CYC = 8,
    parameter int HIGH_MAX  = 75
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic pt_p,
    input logic pt_n,
    input logic live_enc
);

    logic [15:0] zrun, hrun;

    // Length of the current both-low stretch while the carrier is live.
    always_ff @(posedge clk) begin
        if (!rst_n)                          zrun <= '0;
        else if (live_enc && !pt_p && !pt_n) zrun <= zrun + 1'b1;
        else                                 zrun <= '0;
    end

    // Length of the current pt_p high stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    hrun <= '0;
        else if (pt_p) hrun <= hrun + 1'b1;
        else           hrun <= '0;
    end

    // R1: two edges after enable is sampled low, the drive pair is idle.
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> ##2 (!pt_p && !pt_n));

    // R2: the encoded carrier never drives both lines high.
    a_r2_never_both_high: assert property (@(posedge clk) disable iff (!rst_n)
        live_enc |-> !(pt_p && pt_n));

    // R3: a notch never lasts longer than NOTCH_CYC.
    a_r3_notch_width: assert property (@(posedge clk) disable iff (!rst_n)
        zrun <= 16'(NOTCH_CYC));

    // R6: pt_p is never high beyond the largest duty limit.
    a_r6_high_limit: assert property (@(posedge clk) disable iff (!rst_n)
        hrun <= 16'(HIGH_MAX));

endmodule

bind pte_encoder pte_encoder_chk #(
    .NOTCH_CYC (NOTCH_CYC),
    .HIGH_MAX  ((PERIOD * 3) / 4)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .pt_p     (pt_p),
    .pt_n     (pt_n),
    .live_enc (enc_live)
);

// File: tb/pte_encoder_test.sv
`timescale 1ns/1ps
module pte_encoder_test;

    localparam int PERIOD = 100;
    localparam int NOTCH  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] on_time = 8'd0;
    logic       pt_p, pt_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pte_encoder uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode    (mode),
        .on_time (on_time),
        .pt_p    (pt_p),
        .pt_n    (pt_n)
    );

    always #10 clk = ~clk;

    // Expected drive pair for one phase count, from the requirements.
    function automatic logic [1:0] model(input logic [1:0] m, input int on, input int ph);
        int  dmax;
        bit  clip, notch, p, n;
        int  nend;
        dmax  = m[0] ? (PERIOD * 3) / 4 : PERIOD / 2;
        clip  = (on >= dmax);
        nend  = (on + NOTCH > dmax) ? dmax : on + NOTCH;
        notch = !clip && ph >= on && ph < nend;
        if (m[1]) begin
            p = ph < (clip ? dmax : on);
            n = ph < PERIOD / 2;
        end else begin
            p = (ph < dmax) && !notch;
            n = !(ph < dmax);
        end
        return {p, n};
    endfunction

    task automatic check_pair(input string tag, input logic [1:0] exp, input int ph);
        checks++;
        if ({pt_p, pt_n} !== exp) begin
            errors++;
            $display("FAIL %s ph=%0d actual p/n=%b expected p/n=%b", tag, ph, {pt_p, pt_n}, exp);
        end
    endtask

    // Disable and confirm the idle level (R1).
    task automatic stop_and_check(input string tag);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        check_pair({tag, " R1 idle"}, 2'b00, -1);
        repeat (3) @(negedge clk);
    endtask

    // One scenario: run two full periods with a fixed request.
    task automatic run_case(input logic [1:0] m, input int on, input string tag);
        mode    = m;
        on_time = 8'(on);
        enable  = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 2 * PERIOD; i++) begin
            check_pair(tag, model(m, on, i % PERIOD), i % PERIOD);
            @(negedge clk);
        end
        stop_and_check(tag);
    endtask

    // R9: request and mode changed mid-period apply from the next period.
    task automatic midcycle_case();
        mode    = 2'b00;
        on_time = 8'd20;
        enable  = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 2 * PERIOD; i++) begin
            if (i < PERIOD) check_pair("R9 period0", model(2'b00, 20, i), i);
            else            check_pair("R9 period1", model(2'b01, 30, i - PERIOD), i - PERIOD);
            if (i == 5) begin
                on_time = 8'd30;
                mode    = 2'b01;
            end
            @(negedge clk);
        end
        stop_and_check("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_pair("R1 reset", 2'b00, -1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_pair("R1 disabled", 2'b00, -1);

        run_case(2'b00, 20,  "R2 R3 enc50 mid");
        run_case(2'b00, 0,   "R4 enc50 zero");
        run_case(2'b00, 45,  "R5 enc50 cut notch");
        run_case(2'b00, 60,  "R6 enc50 clipped");
        run_case(2'b01, 60,  "R8 R3 enc75 notch");
        run_case(2'b01, 70,  "R5 enc75 cut notch");
        run_case(2'b10, 30,  "R7 plain50");
        run_case(2'b11, 90,  "R6 R7 R8 plain75 clipped");
        run_case(2'b10, 0,   "R7 plain50 zero");
        midcycle_case();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule